// File: doc/BRIEF.md
# UART Transmit Buffer with Refill Threshold Flag

This block sits between a host register interface and a UART serializer. The host writes bytes into a first-in first-out buffer. The serializer takes them one at a time through a valid/ready handshake. A programmable watermark and a sticky refill flag tell software when the buffer has drained far enough to need more data. The flag can also drive an interrupt line. Baud timing, the shift register and the receive side are outside the block.

The buffer depth is chosen at run time by an enable bit and a size code. With the enable low, the block acts as a single holding register. The refill flag is cleared by a two-step handshake: a status read while the flag is up, then a later data write. Because the flag re-arms as long as the occupancy stays at or below the watermark, a clear only holds once enough bytes are queued. A flush empties the buffer without touching the byte the serializer is already shifting. A byte written into a full buffer is dropped and recorded in a sticky overflow bit.

Top module: `uart_txq_top`

## Requirements
- R1: `level` equals the number of bytes held. A byte is removed in the cycle `tx_valid` and `tx_ready` are both high, and it no longer counts while it is shifted out. `tx_valid` is high exactly when `level` is nonzero and `flush` is low, and `tx_data` always presents the oldest byte held.
- R2: `thr_flag` is set in the cycle after any cycle in which `level` is at or below `watermark`, unless that cycle completes a clear. Once set, it stays set until a clear completes.
- R3: A clear completes on a `wr_en` cycle that comes strictly after a cycle with `stat_rd` high while `thr_flag` was high. `thr_flag` is then low in the following cycle. A write with no such earlier read leaves the flag unchanged.
- R4: If `level` is still at or below `watermark` in the cycle after a clear, `thr_flag` is high again one cycle later.
- R5: The depth is 1 when `fifo_en` is 0 or `size_code` is 0. Otherwise it is 2^(n+1) for code n, and codes above 6 act as 6, which gives 128. A write is accepted only while `level` is below the depth.
- R6: A write while `level` is at or above the depth is discarded, and `ovf` is set in the next cycle. `ovf` stays set until a cycle with `ovf_clr` high and no dropped write.
- R7: `flush` sets `level` to 0 in the next cycle. A write or a hand-off in the same cycle is discarded. A byte already taken by the serializer is unaffected.
- R8: `irq` is high exactly when both `thr_flag` and `irq_en` are high.
- R9: `tx_done` is high exactly when `level` is 0 and `ser_busy` is low.
- R10: After reset, `level` is 0, `thr_flag` is 1, `ovf` is 0, and no read of the status is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | Buffer enable; low selects a single holding register |
| size_code | input | 3 | Depth code n, depth 2^(n+1) |
| watermark | input | 8 | Refill threshold in bytes |
| irq_en | input | 1 | Interrupt enable |
| stat_rd | input | 1 | Status register read strobe |
| wr_en | input | 1 | Data register write strobe |
| wr_data | input | 8 | Byte to queue |
| flush | input | 1 | Empty the buffer |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow bit |
| tx_valid | output | 1 | Byte available to the serializer |
| tx_data | output | 8 | Oldest queued byte |
| tx_ready | input | 1 | Serializer accepts a byte |
| ser_busy | input | 1 | Serializer is shifting a byte |
| level | output | 8 | Bytes held in the buffer |
| thr_flag | output | 1 | Sticky refill flag |
| irq | output | 1 | Refill interrupt |
| ovf | output | 1 | Sticky overflow status |
| tx_done | output | 1 | Buffer empty and serializer idle |

## Verification
The assertions assume that `fifo_en` and `size_code` change only while the buffer is empty. The occupancy bound against the current depth relies on this, and so do the pointer wrap points. The stimulus follows this rule: before each reprogramming it issues a flush and then spends one cycle with no write. The flag properties also assume that `wr_en` is the only event that can complete a clear, so no other input is allowed to act on the flag. The random phase keeps the configuration fixed and varies only the strobes, the flush and the serializer stall.

// File: rtl/uart_txq_pkg.sv
// Package: shared depth decoding for the transmit buffer.
// Assumes size codes are unsigned and that the maximum code keeps the depth
// within the storage built by the top module.
package uart_txq_pkg;

    // Decode enable and size code into a word depth, clipping large codes.
    function automatic int unsigned txq_depth(input logic en,
                                              input int unsigned code,
                                              input int unsigned max_code);
        int unsigned eff;
        if (!en || code == 0) begin
            return 1;
        end
        eff = (code > max_code) ? max_code : code;
        return 32'd1 << (eff + 1);
    endfunction

endpackage

// File: rtl/uart_txq_depth.sv
// Module: turns the enable bit and size code into the active buffer depth.
// Assumes CNT_W is wide enough to hold 2^(MAX_CODE+1).
module uart_txq_depth #(
    parameter int MAX_CODE = 6,
    parameter int CODE_W   = 3,
    parameter int CNT_W    = 8
) (
    input  logic              fifo_en,
    input  logic [CODE_W-1:0] size_code,
    output logic [CNT_W-1:0]  depth
);
    import uart_txq_pkg::*;

    // Purpose: combinational depth decode through the shared function.
    always_comb begin
        depth = CNT_W'(txq_depth(fifo_en, int'(unsigned'(size_code)), MAX_CODE));
    end

endmodule

// File: rtl/uart_txq_store.sv
// Module: circular byte storage with read/write pointers and occupancy count.
// Assumes depth changes only while the store is empty. Both pointers follow
// the same wrap rule, so the ordering holds even if a pointer sits past the
// new depth when the depth changes.
module uart_txq_store #(
    parameter int DATA_W    = 8,
    parameter int PTR_W     = 7,
    parameter int CNT_W     = 8,
    parameter int MAX_DEPTH = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  depth,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              flush,
    input  logic              pop_rdy,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [CNT_W-1:0]  count,
    output logic              dropped
);
    logic [DATA_W-1:0] mem [MAX_DEPTH];
    logic [PTR_W-1:0]  rd_ptr_q, wr_ptr_q;
    logic [CNT_W-1:0]  count_q;
    logic [CNT_W-1:0]  last_idx;
    logic              accept, pop, has_room;

    // Purpose: handshake and admission decode.
    always_comb begin
        last_idx  = depth - 1'b1;
        has_room  = count_q < depth;
        out_valid = (count_q != '0) && !flush;
        pop       = out_valid && pop_rdy;
        accept    = push_req && !flush && has_room;
        dropped   = push_req && !flush && !has_room;
        out_data  = mem[rd_ptr_q];
        count     = count_q;
    end

    // Purpose: store accepted bytes (no reset on the array).
    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wr_ptr_q] <= push_data;
        end
    end

    // Purpose: advance pointers and occupancy, flush taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            count_q  <= '0;
        end else if (flush) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (accept) begin
                wr_ptr_q <= ({1'b0, wr_ptr_q} == last_idx) ? '0 : wr_ptr_q + 1'b1;
            end
            if (pop) begin
                rd_ptr_q <= ({1'b0, rd_ptr_q} == last_idx) ? '0 : rd_ptr_q + 1'b1;
            end
            if (accept && !pop) begin
                count_q <= count_q + 1'b1;
            end else if (pop && !accept) begin
                count_q <= count_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/uart_txq_flag.sv
// Module: sticky refill flag with a read-then-write clear sequence.
// Assumes the read strobe and the write strobe are single-cycle register
// access pulses. A clear needs the read in an earlier cycle than the write.
module uart_txq_flag #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] level,
    input  logic [CNT_W-1:0] watermark,
    input  logic             stat_rd,
    input  logic             wr_strobe,
    output logic             flag
);
    logic flag_q, armed_q, at_or_below, clear_now;

    // Purpose: threshold compare and clear-event decode.
    always_comb begin
        at_or_below = level <= watermark;
        clear_now   = armed_q && wr_strobe;
        flag        = flag_q;
    end

    // Purpose: hold the flag and the read-pending step of the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q  <= 1'b1;
            armed_q <= 1'b0;
        end else if (clear_now) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            flag_q  <= flag_q | at_or_below;
            armed_q <= armed_q | (stat_rd && flag_q);
        end
    end

endmodule

// File: rtl/uart_txq_top.sv
// Module: UART transmit buffer top. It ties together depth decode, storage,
// the refill flag, the overflow status and the done indication.
// Assumes fifo_en and size_code are reprogrammed only while the buffer is
// empty, and that ser_busy comes from the downstream serializer.
module uart_txq_top #(
    parameter  int DATA_W    = 8,
    parameter  int MAX_CODE  = 6,
    parameter  int CODE_W    = 3,
    localparam int PTR_W     = MAX_CODE + 1,
    localparam int CNT_W     = PTR_W + 1,
    localparam int MAX_DEPTH = 1 << PTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic [CODE_W-1:0] size_code,
    input  logic [CNT_W-1:0]  watermark,
    input  logic              irq_en,
    input  logic              stat_rd,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              flush,
    input  logic              ovf_clr,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              ser_busy,
    output logic [CNT_W-1:0]  level,
    output logic              thr_flag,
    output logic              irq,
    output logic              ovf,
    output logic              tx_done
);
    logic [CNT_W-1:0] depth_w;
    logic             dropped_w;
    logic             ovf_q;

    uart_txq_depth #(
        .MAX_CODE (MAX_CODE),
        .CODE_W   (CODE_W),
        .CNT_W    (CNT_W)
    ) u_depth (
        .fifo_en   (fifo_en),
        .size_code (size_code),
        .depth     (depth_w)
    );

    uart_txq_store #(
        .DATA_W    (DATA_W),
        .PTR_W     (PTR_W),
        .CNT_W     (CNT_W),
        .MAX_DEPTH (MAX_DEPTH)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .depth     (depth_w),
        .push_req  (wr_en),
        .push_data (wr_data),
        .flush     (flush),
        .pop_rdy   (tx_ready),
        .out_valid (tx_valid),
        .out_data  (tx_data),
        .count     (level),
        .dropped   (dropped_w)
    );

    uart_txq_flag #(
        .CNT_W (CNT_W)
    ) u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (level),
        .watermark (watermark),
        .stat_rd   (stat_rd),
        .wr_strobe (wr_en),
        .flag      (thr_flag)
    );

    // Purpose: sticky overflow status, a new drop winning over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (dropped_w) begin
            ovf_q <= 1'b1;
        end else if (ovf_clr) begin
            ovf_q <= 1'b0;
        end
    end

    // Purpose: drive the status outputs.
    always_comb begin
        ovf     = ovf_q;
        irq     = thr_flag && irq_en;
        tx_done = (level == '0) && !ser_busy;
    end

endmodule

// File: rtl/uart_txq_chk.sv
// Checker: temporal properties of the transmit buffer, bound into the top.
// Assumes the configuration changes only while the buffer is empty.
module uart_txq_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             flush,
    input logic             ovf_clr,
    input logic             tx_valid,
    input logic [CNT_W-1:0] level,
    input logic [CNT_W-1:0] depth,
    input logic [CNT_W-1:0] watermark,
    input logic             thr_flag,
    input logic             ovf
);
    // R1: an empty buffer never offers a byte
    p_no_valid_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |-> !tx_valid);

    // R2: the flag holds without a write
    p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_flag && !wr_en) |=> thr_flag);

    // R3: the flag only falls after a write
    p_clear_by_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(thr_flag) |-> $past(wr_en));

    // R4: low occupancy without a write re-arms the flag
    p_rearm_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((level <= watermark) && !wr_en) |=> thr_flag);

    // R5: occupancy never exceeds the active depth
    p_level_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        level <= depth);

    // R6: a write into a full buffer raises overflow
    p_drop_sets_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush && (level >= depth)) |=> ovf);

    // R6: overflow holds until cleared
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    // R7: a flush empties the buffer
    p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0));

endmodule

bind uart_txq_top uart_txq_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .flush     (flush),
    .ovf_clr   (ovf_clr),
    .tx_valid  (tx_valid),
    .level     (level),
    .depth     (depth_w),
    .watermark (watermark),
    .thr_flag  (thr_flag),
    .ovf       (ovf)
);

// File: tb/uart_txq_top_tb.sv
// Bench: behavioural queue model of the buffer, flag and serializer,
// compared with the design every cycle.
module uart_txq_top_tb;
    localparam int CLK_P   = 10;
    localparam int SER_LEN = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b1;
    logic [2:0] size_code = 3'd2;
    logic [7:0] watermark = 8'd2;
    logic       irq_en = 1'b1;
    logic       stat_rd = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       flush = 1'b0;
    logic       ovf_clr = 1'b0;
    logic       hold = 1'b1;
    logic       tx_valid, tx_ready, ser_busy, thr_flag, irq, ovf, tx_done;
    logic [7:0] tx_data, level;

    int   vectors = 0;
    int   errors  = 0;
    int   ser_cnt = 0;
    byte unsigned q[$];
    bit   m_flag = 1'b1;
    bit   m_arm  = 1'b0;
    bit   m_ovf  = 1'b0;
    logic [31:0] rs = 32'h1234_abcd;

    always #(CLK_P/2) clk = ~clk;

    assign ser_busy = (ser_cnt != 0);
    assign tx_ready = (ser_cnt == 0) && !hold;

    uart_txq_top u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .size_code(size_code),
        .watermark(watermark), .irq_en(irq_en), .stat_rd(stat_rd),
        .wr_en(wr_en), .wr_data(wr_data), .flush(flush), .ovf_clr(ovf_clr),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .ser_busy(ser_busy), .level(level), .thr_flag(thr_flag), .irq(irq),
        .ovf(ovf), .tx_done(tx_done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int m_depth();
        int c;
        if (!fifo_en || size_code == 0) return 1;
        c = (int'(size_code) > 6) ? 6 : int'(size_code);
        return 1 << (c + 1);
    endfunction

    task automatic compare();
        bit ev;
        ev = (q.size() != 0) && !flush;
        check(int'(level) == q.size(), "R1 level", int'(level), q.size());
        check(tx_valid == ev, "R1/R7 tx_valid", int'(tx_valid), int'(ev));
        if (ev) check(int'(tx_data) == int'(q[0]), "R1 tx_data", int'(tx_data), int'(q[0]));
        check(thr_flag == m_flag, "R2/R3/R4 thr_flag", int'(thr_flag), int'(m_flag));
        check(irq == (m_flag && irq_en), "R8 irq", int'(irq), int'(m_flag && irq_en));
        check(ovf == m_ovf, "R6 ovf", int'(ovf), int'(m_ovf));
        check(tx_done == (q.size() == 0 && ser_cnt == 0), "R9 tx_done",
              int'(tx_done), int'(q.size() == 0 && ser_cnt == 0));
    endtask

    task automatic model_update();
        bit pop, acc, drop, clr;
        int d;
        d    = m_depth();
        pop  = (q.size() != 0) && !flush && tx_ready;
        acc  = wr_en && !flush && (q.size() < d);
        drop = wr_en && !flush && (q.size() >= d);
        clr  = m_arm && wr_en;
        if (clr) begin
            m_flag = 1'b0;
            m_arm  = 1'b0;
        end else begin
            m_arm  = m_arm || (stat_rd && m_flag);
            m_flag = m_flag || (q.size() <= int'(watermark));
        end
        if (drop) m_ovf = 1'b1;
        else if (ovf_clr) m_ovf = 1'b0;
        if (pop) ser_cnt = SER_LEN;
        else if (ser_cnt > 0) ser_cnt--;
        if (flush) q.delete();
        else begin
            if (pop) void'(q.pop_front());
            if (acc) q.push_back(wr_data);
        end
    endtask

    // One cycle: inputs are set, compare before the edge, update after it.
    task automatic tick();
        #1;
        compare();
        @(posedge clk);
        #1;
        model_update();
        @(negedge clk);
    endtask

    task automatic put(input byte unsigned d);
        wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic reprogram(input bit en, input int code, input int wm);
        flush = 1'b1; tick(); flush = 1'b0;
        fifo_en = en; size_code = 3'(code); watermark = 8'(wm);
        tick();
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog expired (R1..) actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        check(level == 0, "R10 level after reset", int'(level), 0);
        check(thr_flag == 1'b1, "R10 flag after reset", int'(thr_flag), 1);
        check(ovf == 1'b0, "R10 ovf after reset", int'(ovf), 0);
        check(tx_valid == 1'b0, "R10 tx_valid after reset", int'(tx_valid), 0);
        idle(2);

        // R3: writes without a prior status read leave the flag set
        hold = 1'b1;
        for (int i = 0; i < 4; i++) put(byte'(8'h10 + i));
        check(thr_flag == 1'b1, "R3 no-read write keeps flag", int'(thr_flag), 1);
        // R3: read then write clears; level 5 is above the watermark of 2
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
        put(8'h55);
        check(thr_flag == 1'b0, "R3 flag cleared", int'(thr_flag), 0);
        idle(2);
        // R6: fill depth 8 and overflow
        for (int i = 0; i < 4; i++) put(byte'(8'h20 + i));
        check(level == 8, "R5 depth 8 full", int'(level), 8);
        put(8'hee);
        check(ovf == 1'b1, "R6 ovf set", int'(ovf), 1);
        idle(2);
        ovf_clr = 1'b1; tick(); ovf_clr = 1'b0;
        check(ovf == 1'b0, "R6 ovf cleared", int'(ovf), 0);
        // R2: drain, flag returns at or below the watermark
        hold = 1'b0; idle(40);
        check(thr_flag == 1'b1, "R2 flag after drain", int'(thr_flag), 1);

        // R4: clear while still low re-arms one cycle later
        hold = 1'b1;
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
        put(8'h77);
        check(thr_flag == 1'b0, "R4 flag low after clear", int'(thr_flag), 0);
        tick();
        check(thr_flag == 1'b1, "R4 flag reasserts", int'(thr_flag), 1);

        // R7: flush with a byte in the serializer
        hold = 1'b0; tick(); hold = 1'b1;
        for (int i = 0; i < 5; i++) put(byte'(8'h30 + i));
        flush = 1'b1; wr_en = 1'b1; wr_data = 8'h99; tick(); flush = 1'b0; wr_en = 1'b0;
        check(level == 0, "R7 level after flush", int'(level), 0);
        idle(6);

        // R5: enable low gives a single holding register
        reprogram(1'b0, 6, 0);
        put(8'h41); put(8'h42);
        check(level == 1, "R5 disabled depth 1", int'(level), 1);
        ovf_clr = 1'b1; tick(); ovf_clr = 1'b0;

        // R5: code 7 clips to depth 128
        reprogram(1'b1, 7, 64);
        for (int i = 0; i < 130; i++) put(byte'(i));
        check(level == 128, "R5 clipped depth 128", int'(level), 128);
        hold = 1'b0; idle(450); hold = 1'b1;

        // R5: code 0 gives depth 1, code 1 gives depth 4
        reprogram(1'b1, 0, 0);
        put(8'h61); put(8'h62);
        check(level == 1, "R5 code 0 depth 1", int'(level), 1);
        reprogram(1'b1, 1, 1);
        for (int i = 0; i < 6; i++) put(byte'(8'h70 + i));
        check(level == 4, "R5 code 1 depth 4", int'(level), 4);
        ovf_clr = 1'b1; tick(); ovf_clr = 1'b0;

        // Mixed traffic: R1, R2, R3, R6, R7, R8, R9 under random strobes
        reprogram(1'b1, 3, 5);
        for (int i = 0; i < 4000; i++) begin
            rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
            wr_en   = (rs[2:0] < 3'd3);
            wr_data = rs[15:8];
            stat_rd = rs[4];
            hold    = (rs[6:5] == 2'd0);
            flush   = (rs[13:7] == 7'd0);
            ovf_clr = (rs[20:18] == 3'd0);
            irq_en  = rs[21] | rs[22];
            tick();
        end
        wr_en = 1'b0; stat_rd = 1'b0; flush = 1'b0; ovf_clr = 1'b0; hold = 1'b0;
        idle(60);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule